// File: doc/BRIEF.md
# Dual-Channel Bus-Master Interrupt Status

This block holds the bus-master command and status state for the two channels of a disk interface controller, together with the interrupt-pending logic that decides when each channel raises its interrupt line. Each channel's transfer engine reports the end of a transfer with a single-cycle done pulse, or with an error pulse when the transfer failed. Either pulse stops the channel and records the event in three places: the status interrupt bit, a per-channel pending flag in a shared mode register, and a per-channel pending flag in a configuration byte.

Software reaches all of this through a simple byte-wide register port. Writes take effect on the next clock edge. Reads are combinational from the current state. The status error and interrupt bits and every pending flag are cleared by writing one to them. A channel's interrupt output is raised only when its status interrupt bit and its mode-register pending flag are both set and its blocking bit is clear. A per-channel clean-completion output shows when the low three status bits read 100b. The configuration-space pending flag does not gate the interrupt; software must clear it on its own after each transfer.

Top module: `dual_bm_irq`

## Requirements
- R1: After reset every readable byte at addresses 0 to 7 reads 0x00 with the default parameters, and irq_o, irq_any and xfer_ok are all low.
- R2: The command byte of channel c is at address 2c. Writing it stores wr_data bit 0 as the run bit, which reads back at bit 0, and sets the status active bit (bit 0) to the same value: writing 1 starts the channel and writing 0 stops it. The other command bits read 0.
- R3: A done pulse on channel c clears that channel's active bit and sets its status interrupt bit (bit 2), its mode pending flag and its configuration pending flag, all visible one cycle after the pulse.
- R4: An error pulse on channel c has every effect of a done pulse and also sets the status error bit (bit 1).
- R5: The status byte of channel c is at address 2c+1. Writing 1 to bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. Bits 5 and 6 (drive-0 and drive-1 DMA capable) read back as written. Bit 7 reads the SIMPLEX_MASK parameter bit for the channel. Bits 0, 3 and 4 are not changed by a status write, and bits 3 and 4 read 0.
- R6: The mode byte is at address 4. Bit 2 is the pending flag of channel 0 and bit 3 that of channel 1; writing 1 clears a flag and writing 0 leaves it unchanged. Bit 4 is the blocking bit of channel 0 and bit 5 that of channel 1; both read back as written. The other bits read 0.
- R7: The configuration pending flag of channel 0 is bit 1 of address 5, and that of channel 1 is bit 4 of address 6. Writing 1 to the flag clears it. All other bits of those bytes read 0.
- R8: irq_o[c] is high exactly when status bit 2 and the mode pending flag of channel c are set and its blocking bit is clear. irq_any is the OR of both irq_o bits.
- R9: While a channel is blocked, pulses still set its status interrupt bit and both of its pending flags. Clearing the blocking bit then raises irq_o with no further event.
- R10: A done or error pulse that arrives in the same cycle as a write-one-to-clear, or as a command write, wins: the flag ends up set and the active bit ends up clear.
- R11: xfer_ok[c] is high exactly when status bits 2, 1 and 0 of channel c read 1, 0 and 0.
- R12: Address 7 reads 0x00, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| done_pulse | input | 2 | Per-channel transfer-done pulse |
| err_pulse | input | 2 | Per-channel transfer-error pulse |
| irq_o | output | 2 | Per-channel interrupt line |
| irq_any | output | 1 | OR of both channel interrupts |
| xfer_ok | output | 2 | Per-channel clean-completion flag |

## Verification
The assertions assume that wr_addr, wr_data and both pulse vectors carry known values whenever the block is out of reset. They also assume that done and error pulses may arrive at any time, including together with each other or with a register write. The bench drives every input on the falling edge, holds all of them low through reset, and deliberately sends pulses in the same cycle as clearing writes so that the priority rule is exercised rather than avoided. Its sweeps cover all 256 write values at every status, mode and configuration address, and a long stretch of mixed writes and pulses is compared against a bench model built from the requirements.

// File: rtl/dual_bm_irq_pkg.sv
package dual_bm_irq_pkg;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 3;

    // register map
    localparam logic [ADDR_W-1:0] ADR_CMD0  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_STAT0 = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CMD1  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_STAT1 = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_CFG0  = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_CFG1  = 3'd6;

    // status byte fields
    localparam int unsigned ST_ACT  = 0;
    localparam int unsigned ST_ERR  = 1;
    localparam int unsigned ST_IRQ  = 2;
    localparam int unsigned ST_CAP0 = 5;
    localparam int unsigned ST_CAP1 = 6;
    localparam int unsigned ST_SPX  = 7;

    // command and mode byte fields
    localparam int unsigned CMD_RUN      = 0;
    localparam int unsigned MD_PEND_BASE = 2;
    localparam int unsigned MD_BLK_BASE  = 4;

    localparam logic [2:0] XFER_OK_CODE = 3'b100;

    function automatic logic [ADDR_W-1:0] cmd_addr(input int unsigned ch);
        return ADDR_W'(2 * ch);
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int unsigned ch);
        return ADDR_W'(2 * ch + 1);
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_addr(input int unsigned ch);
        return ADDR_W'(5 + ch);
    endfunction

    function automatic int unsigned cfg_pend_bit(input int unsigned ch);
        return (ch == 0) ? 1 : 4;
    endfunction

    typedef struct packed {
        logic       run;
        logic       act;
        logic       err;
        logic       irq;
        logic [1:0] cap;
        logic       cpend;
    } chan_state_t;

    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic [NUM_CH-1:0] blk;
    } mode_state_t;

endpackage

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
    import dual_bm_irq_pkg::*;
#(
    parameter int unsigned CH      = 0,
    parameter logic        SIMPLEX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              done_p,
    input  logic              err_p,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] cfg_byte,
    output logic              irq_flag,
    output logic              xfer_ok
);

    localparam logic [ADDR_W-1:0] A_CMD  = cmd_addr(CH);
    localparam logic [ADDR_W-1:0] A_STAT = stat_addr(CH);
    localparam logic [ADDR_W-1:0] A_CFG  = cfg_addr(CH);
    localparam int unsigned       PBIT   = cfg_pend_bit(CH);

    chan_state_t st_d, st_q;
    logic        hit_cmd, hit_stat, hit_cfg, event_any;
    logic        unused_wdata;

    assign unused_wdata = ^wr_data;

    always_comb begin
        st_d      = st_q;
        hit_cmd   = wr_en && (wr_addr == A_CMD);
        hit_stat  = wr_en && (wr_addr == A_STAT);
        hit_cfg   = wr_en && (wr_addr == A_CFG);
        event_any = done_p || err_p;

        if (hit_cmd) begin
            st_d.run = wr_data[CMD_RUN];
            st_d.act = wr_data[CMD_RUN];
        end
        if (hit_stat) begin
            if (wr_data[ST_ERR]) st_d.err = 1'b0;
            if (wr_data[ST_IRQ]) st_d.irq = 1'b0;
            st_d.cap = wr_data[ST_CAP1:ST_CAP0];
        end
        if (hit_cfg && wr_data[PBIT]) begin
            st_d.cpend = 1'b0;
        end
        // engine events override any same-cycle software write
        if (event_any) begin
            st_d.act   = 1'b0;
            st_d.irq   = 1'b1;
            st_d.cpend = 1'b1;
            if (err_p) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cmd_byte          = '0;
        cmd_byte[CMD_RUN] = st_q.run;

        stat_byte                  = '0;
        stat_byte[ST_ACT]          = st_q.act;
        stat_byte[ST_ERR]          = st_q.err;
        stat_byte[ST_IRQ]          = st_q.irq;
        stat_byte[ST_CAP1:ST_CAP0] = st_q.cap;
        stat_byte[ST_SPX]          = SIMPLEX;

        cfg_byte       = '0;
        cfg_byte[PBIT] = st_q.cpend;
    end

    assign irq_flag = st_q.irq;
    assign xfer_ok  = ({st_q.irq, st_q.err, st_q.act} == XFER_OK_CODE);

endmodule

// File: rtl/bm_mode_reg.sv
module bm_mode_reg
    import dual_bm_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] ev,
    output logic [BYTE_W-1:0] mode_byte,
    output logic [NUM_CH-1:0] pend,
    output logic [NUM_CH-1:0] blk
);

    mode_state_t md_d, md_q;
    logic        hit;
    logic        unused_wdata;

    assign unused_wdata = ^wr_data;

    always_comb begin
        md_d = md_q;
        hit  = wr_en && (wr_addr == ADR_MODE);
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit && wr_data[MD_PEND_BASE + c]) md_d.pend[c] = 1'b0;
            if (hit)                              md_d.blk[c]  = wr_data[MD_BLK_BASE + c];
            if (ev[c])                            md_d.pend[c] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) md_q <= '0;
        else        md_q <= md_d;
    end

    always_comb begin
        mode_byte = '0;
        mode_byte[MD_PEND_BASE +: NUM_CH] = md_q.pend;
        mode_byte[MD_BLK_BASE  +: NUM_CH] = md_q.blk;
    end

    assign pend = md_q.pend;
    assign blk  = md_q.blk;

endmodule

// File: rtl/bm_irq_gate.sv
module bm_irq_gate
    import dual_bm_irq_pkg::*;
(
    input  logic [NUM_CH-1:0] irq_flag,
    input  logic [NUM_CH-1:0] pend,
    input  logic [NUM_CH-1:0] blk,
    output logic [NUM_CH-1:0] irq_o,
    output logic              irq_any
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        assign irq_o[c] = irq_flag[c] && pend[c] && !blk[c];
    end

    assign irq_any = |irq_o;

endmodule

// File: rtl/dual_bm_irq.sv
module dual_bm_irq
    import dual_bm_irq_pkg::*;
#(
    parameter logic [1:0] SIMPLEX_MASK = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic [1:0] done_pulse,
    input  logic [1:0] err_pulse,
    output logic [1:0] irq_o,
    output logic       irq_any,
    output logic [1:0] xfer_ok
);

    logic [NUM_CH-1:0][BYTE_W-1:0] cmd_b;
    logic [NUM_CH-1:0][BYTE_W-1:0] stat_b;
    logic [NUM_CH-1:0][BYTE_W-1:0] cfg_b;
    logic [BYTE_W-1:0]             mode_b;
    logic [NUM_CH-1:0]             irq_flag, pend, blk, ev;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bm_chan_regs #(
            .CH      (c),
            .SIMPLEX (SIMPLEX_MASK[c])
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .done_p    (done_pulse[c]),
            .err_p     (err_pulse[c]),
            .cmd_byte  (cmd_b[c]),
            .stat_byte (stat_b[c]),
            .cfg_byte  (cfg_b[c]),
            .irq_flag  (irq_flag[c]),
            .xfer_ok   (xfer_ok[c])
        );
        assign ev[c] = done_pulse[c] || err_pulse[c];
    end

    bm_mode_reg i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ev        (ev),
        .mode_byte (mode_b),
        .pend      (pend),
        .blk       (blk)
    );

    bm_irq_gate i_gate (
        .irq_flag (irq_flag),
        .pend     (pend),
        .blk      (blk),
        .irq_o    (irq_o),
        .irq_any  (irq_any)
    );

    always_comb begin
        unique case (rd_addr)
            ADR_CMD0:  rd_data = cmd_b[0];
            ADR_STAT0: rd_data = stat_b[0];
            ADR_CMD1:  rd_data = cmd_b[1];
            ADR_STAT1: rd_data = stat_b[1];
            ADR_MODE:  rd_data = mode_b;
            ADR_CFG0:  rd_data = cfg_b[0];
            ADR_CFG1:  rd_data = cfg_b[1];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dual_bm_irq_chk.sv
module dual_bm_irq_chk
    import dual_bm_irq_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [BYTE_W-1:0]             wr_data,
    input logic [NUM_CH-1:0]             done_pulse,
    input logic [NUM_CH-1:0]             err_pulse,
    input logic [NUM_CH-1:0]             irq_o,
    input logic [NUM_CH-1:0]             xfer_ok,
    input logic [NUM_CH-1:0][BYTE_W-1:0] stat_b,
    input logic [NUM_CH-1:0][BYTE_W-1:0] cfg_b,
    input logic [BYTE_W-1:0]             mode_b
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam int unsigned PB = cfg_pend_bit(c);

        // R3, R10: an event leaves the channel stopped and flagged in all three places
        assert_event_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (done_pulse[c] || err_pulse[c]) |=>
                (stat_b[c][ST_IRQ] && !stat_b[c][ST_ACT] &&
                 mode_b[MD_PEND_BASE + c] && cfg_b[c][PB]));

        assert_err_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            err_pulse[c] |=> stat_b[c][ST_ERR]);

        assert_w1c_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == stat_addr(c) && wr_data[ST_ERR] && !err_pulse[c])
                |=> !stat_b[c][ST_ERR]);

        assert_w1c_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == cfg_addr(c) && wr_data[PB] &&
             !done_pulse[c] && !err_pulse[c]) |=> !cfg_b[c][PB]);

        assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> (stat_b[c][ST_IRQ] && mode_b[MD_PEND_BASE + c]));

        assert_block_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
            mode_b[MD_BLK_BASE + c] |-> !irq_o[c]);

        assert_ok_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
            xfer_ok[c] |-> (stat_b[c][ST_IRQ] && !stat_b[c][ST_ERR] && !stat_b[c][ST_ACT]));
    end

endmodule

bind dual_bm_irq dual_bm_irq_chk i_dual_bm_irq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse),
    .irq_o      (irq_o),
    .xfer_ok    (xfer_ok),
    .stat_b     (stat_b),
    .cfg_b      (cfg_b),
    .mode_b     (mode_b)
);

// File: tb/test_dual_bm_irq.sv
module test_dual_bm_irq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic [1:0] done_pulse;
    logic [1:0] err_pulse;
    logic [1:0] irq_o;
    logic       irq_any;
    logic [1:0] xfer_ok;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    // bench model, updated from the requirements
    logic [1:0]      m_run, m_act, m_err, m_irq, m_cpend, m_pend, m_blk;
    logic [1:0][1:0] m_cap;

    dual_bm_irq i_dual_bm_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse),
        .irq_o      (irq_o),
        .irq_any    (irq_any),
        .xfer_ok    (xfer_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            0: return {7'b0, m_run[0]};
            1: return {1'b0, m_cap[0], 2'b00, m_irq[0], m_err[0], m_act[0]};
            2: return {7'b0, m_run[1]};
            3: return {1'b0, m_cap[1], 2'b00, m_irq[1], m_err[1], m_act[1]};
            4: return {2'b00, m_blk, m_pend, 2'b00};
            5: return {6'b0, m_cpend[0], 1'b0};
            6: return {3'b0, m_cpend[1], 4'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_tag(input int a);
        case (a)
            0, 2:    return "R2";
            1, 3:    return "R5";
            4:       return "R6";
            5, 6:    return "R7";
            default: return "R12";
        endcase
    endfunction

    task automatic model_reset();
        m_run = '0; m_act = '0; m_err = '0; m_irq = '0;
        m_cpend = '0; m_pend = '0; m_blk = '0; m_cap = '0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [7:0] d,
                              input logic [1:0] dn, input logic [1:0] er);
        for (int c = 0; c < 2; c++) begin
            if (we && a == 3'(2 * c)) begin
                m_run[c] = d[0];
                m_act[c] = d[0];
            end
            if (we && a == 3'(2 * c + 1)) begin
                if (d[1]) m_err[c] = 1'b0;
                if (d[2]) m_irq[c] = 1'b0;
                m_cap[c] = d[6:5];
            end
            if (we && a == 3'd4) begin
                if (d[2 + c]) m_pend[c] = 1'b0;
                m_blk[c] = d[4 + c];
            end
            if (we && a == 3'(5 + c) && d[(c == 0) ? 1 : 4]) m_cpend[c] = 1'b0;
            if (dn[c] || er[c]) begin
                m_act[c] = 1'b0; m_irq[c] = 1'b1; m_pend[c] = 1'b1; m_cpend[c] = 1'b1;
                if (er[c]) m_err[c] = 1'b1;
            end
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic [1:0] dn, input logic [1:0] er);
        wr_en = we; wr_addr = a; wr_data = d; done_pulse = dn; err_pulse = er;
        @(negedge clk);
        wr_en = 1'b0; done_pulse = '0; err_pulse = '0;
        model_step(we, a, d, dn, er);
    endtask

    task automatic check_all(input string phase);
        logic [1:0] e_irq, e_ok;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            chk($sformatf("%s/%s addr %0d", phase, addr_tag(a), a), rd_data, exp_rd(a));
        end
        for (int c = 0; c < 2; c++) begin
            e_irq[c] = m_irq[c] && m_pend[c] && !m_blk[c];
            e_ok[c]  = m_irq[c] && !m_err[c] && !m_act[c];
        end
        chk({phase, "/R8 irq_o"},   {6'b0, irq_o},   {6'b0, e_irq});
        chk({phase, "/R8 irq_any"}, {7'b0, irq_any}, {7'b0, |e_irq});
        chk({phase, "/R11 xfer_ok"}, {6'b0, xfer_ok}, {6'b0, e_ok});
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_addr = '0; done_pulse = '0; err_pulse = '0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_all("R1");

        // R2 start and stop through the command byte
        for (int c = 0; c < 2; c++) begin
            step(1, 3'(2 * c), 8'hFF, 2'b00, 2'b00);
            check_all("R2 start");
            step(1, 3'(2 * c), 8'hFE, 2'b00, 2'b00);
            check_all("R2 stop");
        end

        // R3 done, R4 error on each channel
        for (int c = 0; c < 2; c++) begin
            step(1, 3'(2 * c), 8'h01, 2'b00, 2'b00);
            step(0, 3'd0, 8'h00, 2'(1 << c), 2'b00);
            rd_addr = 3'(2 * c + 1); #1;
            chk("R3 status after done", rd_data, 8'h04);
            @(negedge clk);
            check_all("R3");
            step(1, 3'(2 * c), 8'h01, 2'b00, 2'b00);
            step(0, 3'd0, 8'h00, 2'b00, 2'(1 << c));
            rd_addr = 3'(2 * c + 1); #1;
            chk("R4 status after error", rd_data, 8'h06);
            @(negedge clk);
            check_all("R4");
        end

        // R5 status byte: every write value against set flags
        for (int c = 0; c < 2; c++) begin
            for (int v = 0; v < 256; v++) begin
                step(1, 3'(2 * c), 8'h01, 2'b00, 2'b00);
                step(0, 3'd0, 8'h00, 2'b00, 2'(1 << c));
                step(1, 3'(2 * c + 1), 8'(v), 2'b00, 2'b00);
                check_all("R5 sweep");
            end
        end

        // R6 mode byte: every write value with both pendings set
        for (int v = 0; v < 256; v++) begin
            step(0, 3'd0, 8'h00, 2'b11, 2'b00);
            step(1, 3'd4, 8'(v), 2'b00, 2'b00);
            check_all("R6 sweep");
        end
        step(1, 3'd4, 8'h00, 2'b00, 2'b00);

        // R7 configuration pending bytes, R12 unused address
        for (int a = 5; a < 8; a++) begin
            for (int v = 0; v < 256; v++) begin
                step(0, 3'd0, 8'h00, 2'b11, 2'b00);
                step(1, 3'(a), 8'(v), 2'b00, 2'b00);
                check_all((a == 7) ? "R12 sweep" : "R7 sweep");
            end
        end

        // R8 gating: all combinations of status flag, pending flag, block
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 8; k++) begin
                step(0, 3'd0, 8'h00, 2'(1 << c), 2'b00);
                if (!k[0]) step(1, 3'(2 * c + 1), 8'h04, 2'b00, 2'b00);
                if (!k[1]) step(1, 3'd4, 8'(4 << c), 2'b00, 2'b00);
                step(1, 3'd4, k[2] ? 8'(16 << c) : 8'h00, 2'b00, 2'b00);
                check_all("R8 combo");
            end
        end

        // R9 events recorded while blocked, released on unblock
        step(1, 3'd4, 8'h3C, 2'b00, 2'b00);
        step(1, 3'd1, 8'h06, 2'b00, 2'b00);
        step(1, 3'd3, 8'h06, 2'b00, 2'b00);
        step(1, 3'd4, 8'h30, 2'b00, 2'b00);
        check_all("R9 blocked idle");
        step(0, 3'd0, 8'h00, 2'b01, 2'b10);
        check_all("R9 blocked event");
        chk("R9 quiet while blocked", {6'b0, irq_o}, 8'h00);
        step(1, 3'd4, 8'h00, 2'b00, 2'b00);
        check_all("R9 unblocked");
        chk("R9 released", {6'b0, irq_o}, 8'h03);

        // R10 events beat same-cycle clearing writes and command writes
        step(1, 3'd1, 8'h06, 2'b00, 2'b01);
        check_all("R10 status clear");
        step(1, 3'd4, 8'h0C, 2'b11, 2'b00);
        check_all("R10 mode clear");
        step(1, 3'd6, 8'h10, 2'b10, 2'b00);
        check_all("R10 cfg clear");
        step(1, 3'd2, 8'h01, 2'b10, 2'b00);
        check_all("R10 command start");
        chk("R10 active clear", {7'b0, m_act[1]}, 8'h00);

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] dn, er;
            dn = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
            er = (($urandom % 9) == 0) ? 2'($urandom) : 2'b00;
            step(1'($urandom), 3'($urandom), 8'($urandom), dn, er);
            check_all("mixed");
        end

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule